// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the architectural state changes that happen when a processor takes an exception. A request carries a vector code and an effective address. On the single clock edge that accepts it, the block does all of the following:

- picks the handler fetch address;
- saves the old status word, the effective address and a return PC into dedicated registers;
- rewrites the status word into a privileged state with interrupts and translation switched off;
- clears the delay-slot flag;
- raises a one-cycle pending pulse.

The return PC depends on the class of the exception. It is stepped back one instruction when the faulting instruction sits in a delay slot.

The block holds the small register file it updates: PC, next PC, status, delay-slot flag, saved status, saved effective address and exception PC. The surrounding core writes PC, next PC, status and delay-slot flag through a load port. A debug unit can veto an entry, and a vetoed request changes nothing.

Status bit positions used throughout are:

| Bit | Meaning |
|-----|---------|
| 0 | supervisor |
| 1 | timer interrupt enable |
| 2 | interrupt enable |
| 5 | data translation enable |
| 6 | instruction translation enable |
| 12 | overflow trap enable |
| 14 | high vector base |

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset, PC, next PC, saved status, saved address, exception PC and the delay flag read zero, the status word reads 0x0000_0001 (supervisor only), and the pending output is low.
- R2: A code is accepted only when its low 8 bits are zero and code>>8 lies in 1..13. The handler address is the code plus 0xF000_0000 when status bit 14 is set, and the code alone when that bit is clear. On every accepted entry, next PC takes the handler address, except as R7 states.
- R3: On entry the saved-address register takes the effective-address input, and the saved-status register takes the whole status word as it was before the entry.
- R4: On entry the status word has bits 1, 2, 5, 6 and 12 cleared and bit 0 set; all other bits are kept.
- R5: For indices 2, 3, 4, 6, 7, 9, 10, 11 and 13, the exception PC takes the current PC, minus 4 when the delay flag is set, and PC itself is unchanged.
- R6: For index 12, the exception PC takes current PC + 4, minus 4 when the delay flag is set; PC is unchanged.
- R7: For indices 5 and 8, the exception PC takes the current PC, minus 4 when the delay flag is set. PC becomes the handler address and next PC becomes the handler address + 4.
- R8: For index 1, the exception PC keeps its previous value.
- R9: The delay flag reads 0 after every accepted entry.
- R10: A request made while the debug ignore input is high changes no register and raises no pending pulse.
- R11: A request with an invalid code (low byte non-zero, index 0, or index above 13) changes no register and raises no pending pulse.
- R12: The pending output is high in exactly the cycle that follows each accepting edge, including back-to-back entries.
- R13: With the load strobe high and no accepted entry, PC, next PC, status and delay flag take the load values on the next edge. When an entry is accepted on the same edge, the load values are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req_i | input | 1 | Exception request |
| exc_code_i | input | 32 | Vector code (multiple of 0x100) |
| exc_ea_i | input | 32 | Effective address of the cause |
| dbg_ignore_i | input | 1 | Debug veto of this request |
| core_wr_i | input | 1 | Load strobe for core state |
| core_pc_i | input | 32 | PC load value |
| core_npc_i | input | 32 | Next PC load value |
| core_sr_i | input | 32 | Status load value |
| core_dly_i | input | 1 | Delay-flag load value |
| pc_o | output | 32 | Current PC |
| npc_o | output | 32 | Next PC (fetch address) |
| sr_o | output | 32 | Status word |
| esr_o | output | 32 | Saved status word |
| eear_o | output | 32 | Saved effective address |
| epcr_o | output | 32 | Exception return PC |
| dly_o | output | 1 | Delay-slot flag |
| exc_pend_o | output | 1 | Entry pulse |

## Verification
Every register is an output, so a wrong class decode, a wrong delay adjustment or a lost status bit appears on the ports one edge after the accepting edge. The reference model compares all outputs on every cycle. A wrongly accepted invalid or vetoed request shows up in the same way, as a register that changes and a pending pulse that rises one cycle later. Sequences put back-to-back entries and load-versus-entry collisions next to each other, so that priority errors surface at once.

// File: rtl/excent_pkg.sv
package excent_pkg;
  typedef logic [31:0] word_t;

  typedef enum logic [1:0] {
    CL_RESET   = 2'd0,
    CL_SYNC    = 2'd1,
    CL_SYSCALL = 2'd2,
    CL_ASYNC   = 2'd3
  } exc_class_e;

  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_OVE = 12;
  localparam int SR_EPH = 14;

  localparam word_t SR_RESET = word_t'(1) << SR_SM;

  // Status word as it reads after entry.
  function automatic word_t entry_sr(input word_t sr);
    word_t r;
    r = sr;
    r[SR_OVE] = 1'b0;
    r[SR_IEE] = 1'b0;
    r[SR_TEE] = 1'b0;
    r[SR_DME] = 1'b0;
    r[SR_IME] = 1'b0;
    r[SR_SM]  = 1'b1;
    return r;
  endfunction

  // Return PC: optionally one instruction ahead, stepped back in a delay slot.
  function automatic word_t return_pc(input word_t pc, input logic ahead,
                                      input logic dly, input word_t step);
    word_t fwd;
    word_t back;
    fwd  = ahead ? step : '0;
    back = dly ? step : '0;
    return pc + fwd - back;
  endfunction

  function automatic word_t vector_target(input word_t code, input logic hi,
                                          input word_t base);
    return code + (hi ? base : '0);
  endfunction
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import excent_pkg::*;
#(
  parameter int VEC_MAX = 13,
  parameter int VEC_SHIFT = 8
) (
  input  word_t      code,
  output logic       valid,
  output exc_class_e cls
);
  localparam int IDX_W = 32 - VEC_SHIFT;

  logic [IDX_W-1:0] idx;
  logic             low_zero;

  assign idx      = code[31:VEC_SHIFT];
  assign low_zero = (code[VEC_SHIFT-1:0] == '0);
  assign valid    = low_zero && (idx != '0) && (idx <= IDX_W'(VEC_MAX));

  always_comb begin
    case (idx)
      IDX_W'(1):  cls = CL_RESET;
      IDX_W'(5),
      IDX_W'(8):  cls = CL_ASYNC;
      IDX_W'(12): cls = CL_SYSCALL;
      default:    cls = CL_SYNC;
    endcase
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import excent_pkg::*;
#(
  parameter word_t HV_BASE = 32'hF000_0000,
  parameter int    INSN_BYTES = 4
) (
  input  exc_class_e cls,
  input  word_t      code,
  input  word_t      sr,
  input  word_t      pc,
  input  logic       dly,
  output word_t      handler,
  output word_t      pc_next,
  output word_t      npc_next,
  output word_t      sr_next,
  output word_t      epcr_next,
  output logic       epcr_we
);
  localparam word_t STEP = word_t'(INSN_BYTES);

  logic redirect;

  assign redirect  = (cls == CL_ASYNC);
  assign handler   = vector_target(code, sr[SR_EPH], HV_BASE);
  assign pc_next   = redirect ? handler : pc;
  assign npc_next  = redirect ? handler + STEP : handler;
  assign sr_next   = entry_sr(sr);
  assign epcr_we   = (cls != CL_RESET);
  assign epcr_next = return_pc(pc, cls == CL_SYSCALL, dly, STEP);
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import excent_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  logic  load,
  input  word_t ld_pc,
  input  word_t ld_npc,
  input  word_t ld_sr,
  input  logic  ld_dly,
  input  word_t ex_pc,
  input  word_t ex_npc,
  input  word_t ex_sr,
  input  word_t ex_ea,
  input  word_t ex_epcr,
  input  logic  ex_epcr_we,
  output word_t pc_q,
  output word_t npc_q,
  output word_t sr_q,
  output word_t esr_q,
  output word_t eear_q,
  output word_t epcr_q,
  output logic  dly_q,
  output logic  pend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      npc_q  <= '0;
      sr_q   <= SR_RESET;
      esr_q  <= '0;
      eear_q <= '0;
      epcr_q <= '0;
      dly_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= take;
      if (take) begin
        pc_q   <= ex_pc;
        npc_q  <= ex_npc;
        esr_q  <= sr_q;
        sr_q   <= ex_sr;
        eear_q <= ex_ea;
        dly_q  <= 1'b0;
        if (ex_epcr_we) epcr_q <= ex_epcr;
      end else if (load) begin
        pc_q  <= ld_pc;
        npc_q <= ld_npc;
        sr_q  <= ld_sr;
        dly_q <= ld_dly;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import excent_pkg::*;
#(
  parameter int    VEC_MAX = 13,
  parameter word_t HV_BASE = 32'hF000_0000,
  parameter int    INSN_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        exc_req_i,
  input  logic [31:0] exc_code_i,
  input  logic [31:0] exc_ea_i,
  input  logic        dbg_ignore_i,
  input  logic        core_wr_i,
  input  logic [31:0] core_pc_i,
  input  logic [31:0] core_npc_i,
  input  logic [31:0] core_sr_i,
  input  logic        core_dly_i,
  output logic [31:0] pc_o,
  output logic [31:0] npc_o,
  output logic [31:0] sr_o,
  output logic [31:0] esr_o,
  output logic [31:0] eear_o,
  output logic [31:0] epcr_o,
  output logic        dly_o,
  output logic        exc_pend_o
);
  logic       code_ok_w;
  exc_class_e cls_w;
  logic       accept_w;
  word_t      handler_w;
  word_t      pc_nx_w;
  word_t      npc_nx_w;
  word_t      sr_nx_w;
  word_t      epcr_nx_w;
  logic       epcr_we_w;

  exc_decode #(.VEC_MAX(VEC_MAX), .VEC_SHIFT(8)) u_dec (
    .code  (exc_code_i),
    .valid (code_ok_w),
    .cls   (cls_w)
  );

  assign accept_w = exc_req_i && !dbg_ignore_i && code_ok_w;

  exc_target #(.HV_BASE(HV_BASE), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .cls       (cls_w),
    .code      (exc_code_i),
    .sr        (sr_o),
    .pc        (pc_o),
    .dly       (dly_o),
    .handler   (handler_w),
    .pc_next   (pc_nx_w),
    .npc_next  (npc_nx_w),
    .sr_next   (sr_nx_w),
    .epcr_next (epcr_nx_w),
    .epcr_we   (epcr_we_w)
  );

  exc_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .take       (accept_w),
    .load       (core_wr_i),
    .ld_pc      (core_pc_i),
    .ld_npc     (core_npc_i),
    .ld_sr      (core_sr_i),
    .ld_dly     (core_dly_i),
    .ex_pc      (pc_nx_w),
    .ex_npc     (npc_nx_w),
    .ex_sr      (sr_nx_w),
    .ex_ea      (exc_ea_i),
    .ex_epcr    (epcr_nx_w),
    .ex_epcr_we (epcr_we_w),
    .pc_q       (pc_o),
    .npc_q      (npc_o),
    .sr_q       (sr_o),
    .esr_q      (esr_o),
    .eear_q     (eear_o),
    .epcr_q     (epcr_o),
    .dly_q      (dly_o),
    .pend_q     (exc_pend_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import excent_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        accept,
  input exc_class_e  cls,
  input logic        req,
  input logic        ign,
  input logic        wr,
  input logic [31:0] ea,
  input logic [31:0] pc,
  input logic [31:0] npc,
  input logic [31:0] sr,
  input logic [31:0] esr,
  input logic [31:0] eear,
  input logic [31:0] epcr,
  input logic        dly,
  input logic        pend
);
  AST_ESR_COPY: assert property (@(posedge clk) disable iff (rst)
    accept |=> esr == $past(sr)); // R3
  AST_EEAR_LOAD: assert property (@(posedge clk) disable iff (rst)
    accept |=> eear == $past(ea)); // R3
  AST_SR_PRIV: assert property (@(posedge clk) disable iff (rst)
    pend |-> (sr[SR_SM] && !sr[SR_IEE] && !sr[SR_TEE] && !sr[SR_DME]
              && !sr[SR_IME] && !sr[SR_OVE])); // R4
  AST_ASYNC_NPC: assert property (@(posedge clk) disable iff (rst)
    (accept && cls == CL_ASYNC) |=> npc == pc + 32'd4); // R7
  AST_RESET_EPCR: assert property (@(posedge clk) disable iff (rst)
    (accept && cls == CL_RESET) |=> $stable(epcr)); // R8
  AST_DLY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    pend |-> !dly); // R9
  AST_IGNORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req && ign && !wr) |=> ($stable(pc) && $stable(npc) && $stable(sr) &&
      $stable(esr) && $stable(eear) && $stable(epcr) && !pend)); // R10
  AST_PEND_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    accept |=> pend); // R12
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .accept (accept_w),
  .cls    (cls_w),
  .req    (exc_req_i),
  .ign    (dbg_ignore_i),
  .wr     (core_wr_i),
  .ea     (exc_ea_i),
  .pc     (pc_o),
  .npc    (npc_o),
  .sr     (sr_o),
  .esr    (esr_o),
  .eear   (eear_o),
  .epcr   (epcr_o),
  .dly    (dly_o),
  .pend   (exc_pend_o)
);

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req_i = 1'b0;
  logic [31:0] exc_code_i = '0;
  logic [31:0] exc_ea_i = '0;
  logic        dbg_ignore_i = 1'b0;
  logic        core_wr_i = 1'b0;
  logic [31:0] core_pc_i = '0;
  logic [31:0] core_npc_i = '0;
  logic [31:0] core_sr_i = '0;
  logic        core_dly_i = 1'b0;
  logic [31:0] pc_o, npc_o, sr_o, esr_o, eear_o, epcr_o;
  logic        dly_o, exc_pend_o;

  always #5 clk = ~clk;

  exc_entry_ctrl dut_i (.*);

  // reference state
  bit [31:0] m_pc, m_npc, m_sr, m_esr, m_eear, m_epcr;
  bit        m_dly, m_pend;
  int        vectors = 0;
  int        miscompares = 0;
  bit        done = 1'b0;
  bit [31:0] lcg = 32'h1234_5678;

  function automatic bit [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic chk32(string tag, string what, bit [31:0] act, bit [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    vectors++;
    chk32(tag, "pc", pc_o, m_pc);
    chk32(tag, "npc", npc_o, m_npc);
    chk32(tag, "sr", sr_o, m_sr);
    chk32(tag, "esr", esr_o, m_esr);
    chk32(tag, "eear", eear_o, m_eear);
    chk32(tag, "epcr", epcr_o, m_epcr);
    chk32(tag, "dly", {31'd0, dly_o}, {31'd0, m_dly});
    chk32(tag, "pend", {31'd0, exc_pend_o}, {31'd0, m_pend});
  endtask

  // Advance the reference by one edge using the inputs now applied.
  task automatic model_edge();
    int  idx;
    bit  ok;
    bit  acc;
    bit [31:0] h;
    bit [31:0] adj;
    idx = int'(exc_code_i >> 8);
    ok  = (exc_code_i % 256 == 0) && idx >= 1 && idx <= 13;
    acc = exc_req_i && !dbg_ignore_i && ok;
    m_pend = acc;
    if (acc) begin
      h   = exc_code_i + (((m_sr >> 14) & 1) != 0 ? 32'hF000_0000 : 32'h0);
      adj = m_dly ? 32'd4 : 32'd0;
      m_esr  = m_sr;
      m_eear = exc_ea_i;
      if (idx == 12)                m_epcr = m_pc + 4 - adj;
      else if (idx != 1)            m_epcr = m_pc - adj;
      if (idx == 5 || idx == 8) begin
        m_pc  = h;
        m_npc = h + 4;
      end else begin
        m_npc = h;
      end
      m_sr  = (m_sr & ~32'h0000_1066) | 32'h1;
      m_dly = 1'b0;
    end else if (core_wr_i) begin
      m_pc  = core_pc_i;
      m_npc = core_npc_i;
      m_sr  = core_sr_i;
      m_dly = core_dly_i;
    end
  endtask

  task automatic cycle(string tag);
    model_edge();
    @(posedge clk);
    #2;
    compare_all(tag);
    @(negedge clk);
    exc_req_i    = 1'b0;
    core_wr_i    = 1'b0;
    dbg_ignore_i = 1'b0;
  endtask

  task automatic load_core(bit [31:0] pc, bit [31:0] sr, bit dly);
    core_wr_i  = 1'b1;
    core_pc_i  = pc;
    core_npc_i = pc + 4;
    core_sr_i  = sr;
    core_dly_i = dly;
    cycle("R13");
  endtask

  task automatic raise(bit [31:0] code, bit ign, string tag);
    exc_req_i    = 1'b1;
    exc_code_i   = code;
    exc_ea_i     = rnd();
    dbg_ignore_i = ign;
    cycle(tag);
  endtask

  function automatic string tag_for(int idx);
    if (idx == 1) return "R8";
    if (idx == 12) return "R6";
    if (idx == 5 || idx == 8) return "R7";
    return "R5";
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_pc = 0; m_npc = 0; m_sr = 32'h1; m_esr = 0; m_eear = 0;
    m_epcr = 0; m_dly = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #2;
    compare_all("R1");                 // R1 reset values
    @(negedge clk);
    rst = 1'b0;

    // every valid index, both delay values, both vector bases (R2 R3 R4 R9 R12)
    for (int i = 1; i <= 13; i++) begin
      for (int k = 0; k < 4; k++) begin
        load_core(rnd() & 32'hFFFF_FFFC, rnd() | (k[1] ? 32'h4000 : 32'h0)
                  & (k[1] ? 32'hFFFF_FFFF : 32'hFFFF_BFFF), k[0]);
        raise(32'(i) << 8, 1'b0, tag_for(i));
        cycle("R12");                  // pulse drops after one cycle
      end
    end

    // back-to-back entries keep the pulse high (R12)
    load_core(32'h0000_4000, 32'h0000_5067, 1'b1);
    raise(32'h0000_0800, 1'b0, "R7");
    raise(32'h0000_0C00, 1'b0, "R6");
    raise(32'h0000_0300, 1'b0, "R12");
    cycle("R12");

    // debug veto (R10)
    for (int k = 0; k < 6; k++) begin
      load_core(rnd() & 32'hFFFF_FFFC, rnd(), k[0]);
      raise(32'(k + 1) << 8, 1'b1, "R10");
    end

    // invalid codes (R11)
    load_core(32'h0000_2000, 32'h0000_1066, 1'b1);
    raise(32'h0000_0000, 1'b0, "R11");
    raise(32'h0000_0E00, 1'b0, "R11");
    raise(32'h0000_0180, 1'b0, "R11");
    raise(32'h0001_0500, 1'b0, "R11");
    raise(32'h0000_0201, 1'b0, "R11");

    // load collides with an entry: entry wins (R13)
    load_core(32'h0000_3000, 32'h0000_0006, 1'b0);
    core_wr_i  = 1'b1;
    core_pc_i  = 32'hDEAD_0000;
    core_npc_i = 32'hDEAD_0004;
    core_sr_i  = 32'hFFFF_FFFF;
    core_dly_i = 1'b1;
    raise(32'h0000_0600, 1'b0, "R13");

    // veto plus load: load still applies (R10 R13)
    core_wr_i = 1'b1;
    core_pc_i = 32'h0000_7000; core_npc_i = 32'h0000_7004;
    core_sr_i = 32'h0000_4000; core_dly_i = 1'b0;
    raise(32'h0000_0200, 1'b1, "R10");
    raise(32'h0000_0500, 1'b0, "R2"); // high vector base taken

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule